// File: doc/BRIEF.md
# DRAM Self-Refresh Entry Controller

This block sits in the command path of a DDR memory controller and takes the DRAM into self-refresh and back out again. Three sources can ask for self-refresh. A software force bit always acts. A panic interrupt acts only while its enable is set. A sleep request acts only while its own enable is set. When any enabled source is active, the controller lets the commands already queued upstream finish. It then closes any open bank with a precharge-all, waits out the precharge time, and issues the self-refresh command with the clock enable driven low.

The DRAM stays in self-refresh for as long as at least one enabled source is active. The bus is deselected and the clock enable stays low. When every enabled source has gone away, the clock enable rises. The controller then waits a fixed exit interval before it accepts commands again. Upstream requests that arrive while entry is in progress, during self-refresh, or during exit are held off with a low ready and are never consumed. A state output lets software poll where the sequence stands.

Top module: `sr_entry_ctrl`

## Requirements
- R1: Reset is synchronous and active low. After reset, status is 0, cke is 1, req_ready is 1 and cmd_bus is NOP (4'b0111).
- R2: The force input starts entry on its own. The panic input starts entry only while panic_en is 1, and the sleep input only while sleep_en is 1. Status reads 1 (draining) in the cycle after an enabled trigger is seen. A trigger whose enable is 0 leaves status at 0 and req_ready at 1.
- R3: In status 0, and in status 1 while queue_pend is 1, a valid request is accepted (req_ready 1). In the following cycle it appears on cmd_bus as {cs_n,ras_n,cas_n,we_n}, with its bank on cmd_bank. The encodings are: activate (req_op 0) 4'b0011, read (1) 4'b0101, write (2) 4'b0100, single-bank precharge (3) 4'b0010 with cmd_all 0.
- R4: Once queue_pend is 0 in status 1, and throughout status 2, 3 and 4, req_ready is 0 and a pending request is not consumed.
- R5: A bank is open after an activate to it and before a precharge to it. If any bank is open when draining ends, the next cycle shows precharge-all (4'b0010 with cmd_all 1) and status 2. The self-refresh command follows exactly T_RP cycles after the precharge-all.
- R6: If no bank is open when draining ends, the self-refresh command appears in the next cycle and no precharge-all is issued.
- R7: The self-refresh command is 4'b0001 with cke 0 in the same cycle, and status becomes 3. While status is 3, cke stays 0 and cmd_bus is deselect (4'b1111).
- R8: Self-refresh is held while any enabled trigger is active. In the cycle after all enabled triggers are inactive, cke is 1 and status is 4. Status returns to 0, with req_ready 1, exactly T_XS cycles after cke rises.
- R9: Outside the cycles given above, cmd_bus shows NOP (4'b0111) while cke is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| force_sr | input | 1 | Software force-self-refresh bit |
| panic_en | input | 1 | Enable for the panic trigger |
| panic_irq | input | 1 | Panic interrupt (level) |
| sleep_en | input | 1 | Enable for sleep-driven entry |
| sleep_req | input | 1 | Sleep request; deassertion means wake |
| queue_pend | input | 1 | Upstream still holds queued transactions |
| req_valid | input | 1 | Request valid |
| req_op | input | 2 | Request opcode: 0 activate, 1 read, 2 write, 3 precharge |
| req_bank | input | BANK_W | Request bank |
| req_ready | output | 1 | Request accepted when high with valid |
| cmd_bus | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| cmd_bank | output | BANK_W | Bank of the issued command |
| cmd_all | output | 1 | All-bank flag for precharge |
| cke | output | 1 | DRAM clock enable |
| status | output | 3 | 0 normal, 1 draining, 2 precharging, 3 self-refresh, 4 exiting |

## Verification
The hardest case to reach from the ports is the choice between precharge-all and a direct self-refresh command. That choice rests on which banks are still open in the very cycle draining ends, and a single-bank precharge accepted during the drain can close the last open bank. The bench sweeps each trigger source against several open-bank patterns, including one where a precharge issued during the drain leaves nothing open. It also checks the wake rule by raising a second trigger before releasing the first, so self-refresh must persist until both are gone.

// File: rtl/sr_pkg.sv
// Package sr_pkg
// Shared state type, request opcodes and DRAM command encodings for the
// self-refresh entry controller. Commands are {cs_n, ras_n, cas_n, we_n}.
package sr_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL  = 3'd0,
        ST_DRAIN   = 3'd1,
        ST_PRECH   = 3'd2,
        ST_SELFREF = 3'd3,
        ST_EXIT    = 3'd4
    } sr_state_e;

    localparam logic [1:0] OP_ACT = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_WR  = 2'd2;
    localparam logic [1:0] OP_PRE = 2'd3;

    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_ACT   = 4'b0011;
    localparam logic [3:0] CMD_RD    = 4'b0101;
    localparam logic [3:0] CMD_WR    = 4'b0100;
    localparam logic [3:0] CMD_PRE   = 4'b0010;
    localparam logic [3:0] CMD_REF   = 4'b0001;
    localparam logic [3:0] CMD_DESEL = 4'b1111;

endpackage

// File: rtl/sr_trigger.sv
// Module sr_trigger
// Merges the three self-refresh sources into one request level. The force
// bit is ungated; panic and sleep each pass only while their enable is set.
// Assumes all inputs are already synchronous to the controller clock.
module sr_trigger #(
    parameter int NUM_SRC = 3
) (
    input  logic force_sr,
    input  logic panic_en,
    input  logic panic_irq,
    input  logic sleep_en,
    input  logic sleep_req,
    output logic trig
);

    logic [NUM_SRC-1:0] src_vec;

    // Gate each source with its enable and collect them in one vector.
    always_comb begin
        src_vec    = '0;
        src_vec[0] = force_sr;
        src_vec[1] = panic_en & panic_irq;
        src_vec[2] = sleep_en & sleep_req;
    end

    // Any enabled source requests self-refresh.
    assign trig = |src_vec;

endmodule

// File: rtl/sr_bank_track.sv
// Module sr_bank_track
// Keeps one open flag per bank: set by an activate, cleared by a precharge
// to that bank or by a precharge-all. Assumes at most one of act_vld and
// pre_vld is high in a cycle.
module sr_bank_track #(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_vld,
    input  logic              pre_vld,
    input  logic [BANK_W-1:0] bank,
    input  logic              clr_all,
    output logic              any_open
);

    logic [NUM_BANKS-1:0] open_vec;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic open_q;

        // Track whether this bank holds an open row.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all)
                open_q <= 1'b0;
            else if (act_vld && bank == BANK_W'(b))
                open_q <= 1'b1;
            else if (pre_vld && bank == BANK_W'(b))
                open_q <= 1'b0;
        end

        assign open_vec[b] = open_q;
    end

    // Reduce the per-bank flags to a single open indication.
    assign any_open = |open_vec;

    a_r5_clear_all_closes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> !any_open);

    a_r5_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (act_vld && !clr_all) |=> any_open);

endmodule

// File: rtl/sr_timer.sv
// Module sr_timer
// Down-counter shared by the precharge wait and the exit wait. A load sets
// the count; done is high while the count is zero. Assumes the loader
// passes the wait length minus one.
module sr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    // Load or count down toward zero, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);

endmodule

// File: rtl/sr_entry_ctrl.sv
// Module sr_entry_ctrl
// Sequences DRAM self-refresh entry and exit: drains queued traffic, closes
// open banks with precharge-all, waits T_RP, issues self-refresh with CKE
// low, holds until every enabled trigger is gone, then raises CKE and waits
// T_XS before accepting traffic. Assumes T_RP >= 1 and T_XS >= 1, and that
// upstream keeps queue_pend high until its queued transactions are sent.
module sr_entry_ctrl
    import sr_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = $clog2(NUM_BANKS),
    parameter int T_RP      = 4,
    parameter int T_XS      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_sr,
    input  logic              panic_en,
    input  logic              panic_irq,
    input  logic              sleep_en,
    input  logic              sleep_req,
    input  logic              queue_pend,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    output logic              req_ready,
    output logic [3:0]        cmd_bus,
    output logic [BANK_W-1:0] cmd_bank,
    output logic              cmd_all,
    output logic              cke,
    output logic [2:0]        status
);

    localparam int T_MAX = (T_RP > T_XS) ? T_RP : T_XS;
    localparam int TW    = $clog2(T_MAX + 1);
    localparam logic [TW-1:0] TRP_M1 = TW'(T_RP - 1);
    localparam logic [TW-1:0] TXS_M1 = TW'(T_XS - 1);

    sr_state_e         state_q;
    logic              trig;
    logic              any_open;
    logic              t_done;
    logic              accept;
    logic              drain_end;
    logic              go_prech;
    logic              go_exit;
    logic              t_load;
    logic [TW-1:0]     t_val;
    logic [3:0]        cmd_q;
    logic [BANK_W-1:0] bank_q;
    logic              all_q;
    logic              cke_q;

    sr_trigger u_trig (
        .force_sr  (force_sr),
        .panic_en  (panic_en),
        .panic_irq (panic_irq),
        .sleep_en  (sleep_en),
        .sleep_req (sleep_req),
        .trig      (trig)
    );

    sr_bank_track #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_vld  (accept && req_op == OP_ACT),
        .pre_vld  (accept && req_op == OP_PRE),
        .bank     (req_bank),
        .clr_all  (go_prech),
        .any_open (any_open)
    );

    sr_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    // Ready: open in normal operation and while queued traffic drains.
    assign req_ready = (state_q == ST_NORMAL) ||
                       (state_q == ST_DRAIN && queue_pend);
    assign accept    = req_valid && req_ready;

    // Transition conditions that also drive the tracker and timer.
    always_comb begin
        drain_end = (state_q == ST_DRAIN) && !accept && !queue_pend;
        go_prech  = drain_end && any_open;
        go_exit   = (state_q == ST_SELFREF) && !trig;
        t_load    = go_prech || go_exit;
        t_val     = go_prech ? TRP_M1 : TXS_M1;
    end

    // Translate an accepted request opcode into its DRAM command.
    function automatic logic [3:0] op_to_cmd(input logic [1:0] op);
        case (op)
            OP_ACT:  return CMD_ACT;
            OP_RD:   return CMD_RD;
            OP_WR:   return CMD_WR;
            default: return CMD_PRE;
        endcase
    endfunction

    // Entry/exit sequencer with registered command bus and clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            cmd_q   <= CMD_NOP;
            bank_q  <= '0;
            all_q   <= 1'b0;
            cke_q   <= 1'b1;
        end else begin
            cmd_q <= CMD_NOP;
            all_q <= 1'b0;
            if (accept) begin
                cmd_q  <= op_to_cmd(req_op);
                bank_q <= req_bank;
            end
            case (state_q)
                ST_NORMAL: begin
                    if (trig)
                        state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (go_prech) begin
                        cmd_q   <= CMD_PRE;
                        all_q   <= 1'b1;
                        state_q <= ST_PRECH;
                    end else if (drain_end) begin
                        cmd_q   <= CMD_REF;
                        cke_q   <= 1'b0;
                        state_q <= ST_SELFREF;
                    end
                end
                ST_PRECH: begin
                    if (t_done) begin
                        cmd_q   <= CMD_REF;
                        cke_q   <= 1'b0;
                        state_q <= ST_SELFREF;
                    end
                end
                ST_SELFREF: begin
                    if (go_exit) begin
                        cke_q   <= 1'b1;
                        state_q <= ST_EXIT;
                    end else begin
                        cmd_q <= CMD_DESEL;
                    end
                end
                ST_EXIT: begin
                    if (t_done)
                        state_q <= ST_NORMAL;
                end
                default: state_q <= ST_NORMAL;
            endcase
        end
    end

    assign cmd_bus  = cmd_q;
    assign cmd_bank = bank_q;
    assign cmd_all  = all_q;
    assign cke      = cke_q;
    assign status   = state_q;

    a_r7_sre_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_bus == CMD_REF) |-> !cke);

    a_r7_selfref_holds_cke: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SELFREF) |-> !cke);

    a_r6_banks_closed_at_sre: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_bus == CMD_REF) |-> !any_open);

    a_r5_prea_enters_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_bus == CMD_PRE && cmd_all) |-> (state_q == ST_PRECH));

    a_r8_cke_rise_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (state_q == ST_EXIT));

    a_r4_selfref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SELFREF && $past(state_q) == ST_SELFREF) |->
            (cmd_bus == CMD_DESEL));

endmodule

// File: tb/sr_entry_ctrl_tb.sv
// Bench for sr_entry_ctrl: sweeps each trigger source against several
// open-bank patterns and checks command timing computed from T_RP/T_XS.
module sr_entry_ctrl_tb;

    localparam int NB   = 8;
    localparam int BW   = 3;
    localparam int TRP  = 4;
    localparam int TXS  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          force_sr = 1'b0, panic_en = 1'b0, panic_irq = 1'b0;
    logic          sleep_en = 1'b0, sleep_req = 1'b0, queue_pend = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [BW-1:0] req_bank = '0;
    logic          req_ready, cmd_all, cke;
    logic [3:0]    cmd_bus;
    logic [BW-1:0] cmd_bank;
    logic [2:0]    status;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sr_entry_ctrl #(.NUM_BANKS(NB), .BANK_W(BW), .T_RP(TRP), .T_XS(TXS)) u_dut (
        .clk(clk), .rst_n(rst_n), .force_sr(force_sr), .panic_en(panic_en),
        .panic_irq(panic_irq), .sleep_en(sleep_en), .sleep_req(sleep_req),
        .queue_pend(queue_pend), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_ready(req_ready), .cmd_bus(cmd_bus),
        .cmd_bank(cmd_bank), .cmd_all(cmd_all), .cke(cke), .status(status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_src(input int src, input logic v);
        case (src)
            0: force_sr = v;
            1: panic_irq = v;
            default: sleep_req = v;
        endcase
    endtask

    // One full entry/exit pass for a trigger source and an open-bank set.
    task automatic run_entry(input int src, input logic [NB-1:0] mask);
        logic [NB-1:0] left;
        int low;
        left = mask;
        low = -1;
        for (int b = NB - 1; b >= 0; b--) if (mask[b]) low = b;
        // Open the requested banks in normal operation (R3 activate).
        for (int b = 0; b < NB; b++) begin
            if (mask[b]) begin
                req_valid = 1'b1; req_op = 2'd0; req_bank = BW'(b);
                @(negedge clk);
                chk("R3 act cmd", int'(cmd_bus), 4'b0011);
                chk("R3 act bank", int'(cmd_bank), b);
                req_valid = 1'b0;
            end
        end
        // Trigger with queued traffic still pending.
        queue_pend = 1'b1; req_valid = 1'b1; req_op = 2'd1; req_bank = '0;
        set_src(src, 1'b1);
        @(negedge clk);
        chk("R2 status drain", int'(status), 1);
        chk("R3 read cmd", int'(cmd_bus), 4'b0101);
        req_op = 2'd2; req_bank = BW'(1);
        @(negedge clk);
        chk("R3 write cmd", int'(cmd_bus), 4'b0100);
        chk("R3 write bank", int'(cmd_bank), 1);
        chk("R9 status drain", int'(status), 1);
        if (low >= 0) begin
            req_op = 2'd3; req_bank = BW'(low);
            @(negedge clk);
            chk("R3 pre cmd", int'(cmd_bus), 4'b0010);
            chk("R3 pre single", int'(cmd_all), 0);
            left[low] = 1'b0;
        end
        // Queue empty: new traffic must be held off.
        queue_pend = 1'b0; req_op = 2'd1;
        #1;
        chk("R4 ready drain end", int'(req_ready), 0);
        @(negedge clk);
        if (left != '0) begin
            chk("R5 prea cmd", int'(cmd_bus), 4'b0010);
            chk("R5 prea all", int'(cmd_all), 1);
            chk("R5 status prech", int'(status), 2);
            chk("R4 ready prech", int'(req_ready), 0);
            for (int i = 1; i < TRP; i++) begin
                @(negedge clk);
                chk("R9 nop during tRP", int'(cmd_bus), 4'b0111);
                chk("R5 cke high tRP", int'(cke), 1);
            end
            @(negedge clk);
        end else begin
            chk("R6 no prea", int'(status), 3);
        end
        chk("R7 sre cmd", int'(cmd_bus), 4'b0001);
        chk("R7 sre cke", int'(cke), 0);
        chk("R7 status sr", int'(status), 3);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R7 desel", int'(cmd_bus), 4'b1111);
            chk("R7 cke low", int'(cke), 0);
            chk("R4 ready sr", int'(req_ready), 0);
        end
        if (src == 2) begin
            // Overlap: force rises before sleep falls; must stay in SR (R8).
            force_sr = 1'b1; sleep_req = 1'b0;
            for (int i = 0; i < 2; i++) begin
                @(negedge clk);
                chk("R8 held by other trigger", int'(status), 3);
                chk("R8 cke still low", int'(cke), 0);
            end
            force_sr = 1'b0;
        end else begin
            set_src(src, 1'b0);
        end
        @(negedge clk);
        chk("R8 cke rises", int'(cke), 1);
        for (int i = 1; i <= TXS; i++) begin
            chk("R8 status exit", int'(status), 4);
            chk("R4 ready exit", int'(req_ready), 0);
            @(negedge clk);
        end
        chk("R8 back to normal", int'(status), 0);
        chk("R8 ready back", int'(req_ready), 1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 nop idle", int'(cmd_bus), 4'b0111);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [NB-1:0] masks [5];
        masks[0] = 8'h00; masks[1] = 8'h01; masks[2] = 8'h80;
        masks[3] = 8'hA5; masks[4] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 status", int'(status), 0);
        chk("R1 cke", int'(cke), 1);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 cmd nop", int'(cmd_bus), 4'b0111);
        @(negedge clk);
        // Disabled sources are ignored (R2).
        panic_irq = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 panic gated", int'(status), 0);
            chk("R2 panic ready", int'(req_ready), 1);
        end
        panic_irq = 1'b0; sleep_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 sleep gated", int'(status), 0);
            chk("R2 sleep ready", int'(req_ready), 1);
        end
        sleep_req = 1'b0;
        panic_en = 1'b1; sleep_en = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 3; s++)
            for (int m = 0; m < 5; m++)
                run_entry(s, masks[m]);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule